// File: doc/BRIEF.md
# Fail-Safe Configuration Watchdog Controller

This controller sits beside the configuration interface of a programmable device and decides which image the device boots. After reset it reads the header of each user image slot in flash. The first slot with a good header is loaded through a start/done handshake. If no slot has a good header, a fixed fallback image is loaded instead. The host can keep several user images in flash at once. The fallback image always leaves the host able to reach flash, so a broken user image can be written again.

Every successful user load arms a watchdog. The host proves the new image is alive by writing a short run of key values, in order, to an unlock register. If the watchdog runs out before the keys arrive, the controller reloads the fallback image and sets a sticky flag. The watchdog never runs while the fallback image is active, so the controller cannot enter a reload loop. The timeout is a cycle count that the host can program. A status register shows the active slot, the watchdog state and the sticky flag.

Top module: `cfg_guard_ctrl`

## Requirements
- R1: After reset, status (address 2) reads 0x004: active slot field [7:0] = 4 (the fallback code, NUM_SLOTS), armed bit [8] = 0, sticky bit [9] = 0. The timeout register (address 1) reads 1000.
- R2: Slot s keeps its header at flash addresses s*16+0 (magic), s*16+1 (size) and s*16+2 (check). A slot is good only when the magic word equals MAGIC and the check word equals size XOR CHK_SEED. No flash read targets a word offset above 2.
- R3: The lowest-numbered good slot is loaded. If every slot is bad, slot code 4 (fallback) is loaded and the sticky bit stays 0.
- R4: A load is one single-cycle cfg_start pulse with cfg_slot valid. The controller then waits for cfg_done.
- R5: When cfg_done ends a user-slot load, the armed bit reads 1 with the loaded slot in the status. When it ends a fallback load, the armed bit reads 0.
- R6: If cfg_done is sampled at clock edge E and no unlock follows, the fallback reload cfg_start (cfg_slot = 4) is high in the cycle that follows edge E+T, where T is the timeout register.
- R7: Writing KEY0=0x5A5A1234, KEY1=0xA5A58765 and KEY2=0x0F1E2D3C in that order to address 0 while armed clears the armed bit, keeps the user slot and starts no later reload.
- R8: Any unlock write whose value is not the next expected key sends the match back to KEY0, and that write does not count as a KEY0 match.
- R9: A timeout reload sets the sticky bit. The bit stays set until reset.
- R10: While the fallback image runs, the watchdog stays off (armed bit 0) and no further cfg_start is issued.
- R11: A write to address 1 sets the timeout to the low 16 data bits, and the value reads back. A write whose low 16 bits are zero leaves the timeout unchanged.
- R12: Unlock writes made while not armed are ignored, so a partial sequence before arming does not count. A final key that lands on the same edge as the expiry unlocks, and no reload follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register address: 0 unlock, 1 timeout, 2 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| flash_rd | output | 1 | Flash read request, one cycle |
| flash_addr | output | FLASH_AW | Flash word address |
| flash_rvalid | input | 1 | Flash read data valid |
| flash_rdata | input | 32 | Flash read data |
| cfg_start | output | 1 | Configuration start pulse |
| cfg_slot | output | SLOT_W | Image slot being loaded; NUM_SLOTS selects the fallback |
| cfg_done | input | 1 | Configuration complete pulse |

## Verification
The bench numbers every clock edge and records the edge at which its device model samples cfg_start and the edge at which it presents cfg_done. Timeout checks therefore compare edge indices: the reload start must be seen exactly T+1 edges after the done edge. Status reads are combinational and are taken at the falling edge after the state change is due. Armed-state reads are placed five edges after the start pulse, which is after the done edge of the fixed three-cycle device model and before the shortest timeout used. For the same-edge race, the bench drives the last key in the half cycle before edge E+T, so both events are sampled at that one edge.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
   localparam logic [1:0] REG_UNLOCK = 2'd0;
   localparam logic [1:0] REG_TMO    = 2'd1;
   localparam logic [1:0] REG_STATUS = 2'd2;

   localparam logic [1:0] HW_MAGIC = 2'd0;
   localparam logic [1:0] HW_SIZE  = 2'd1;
   localparam logic [1:0] HW_CHECK = 2'd2;

   typedef enum logic [2:0] {
      CG_SCAN,
      CG_WAIT,
      CG_ARMED,
      CG_FREE,
      CG_SAFE
   } cg_state_e;

   typedef enum logic [1:0] {
      SC_ISSUE,
      SC_WAIT,
      SC_IDLE
   } sc_state_e;
endpackage

// File: rtl/cfg_hdr_scan.sv
module cfg_hdr_scan
   import cfg_guard_pkg::*;
#(
   parameter int unsigned NUM_SLOTS    = 4,
   parameter int unsigned SLOT_W       = 3,
   parameter int unsigned FLASH_AW     = 8,
   parameter int unsigned SLOT_SHIFT   = 4,
   parameter logic [31:0] MAGIC        = 32'hB17C_F00D,
   parameter logic [31:0] CHK_SEED     = 32'h3C3C_C3C3,
   parameter bit          SCAN_DESCEND = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic                flash_rd,
   output logic [FLASH_AW-1:0] flash_addr,
   input  logic                flash_rvalid,
   input  logic [31:0]         flash_rdata,
   output logic                scan_done,
   output logic                scan_found,
   output logic [SLOT_W-1:0]   scan_slot
);
   localparam logic [SLOT_W-1:0] FIRST = SCAN_DESCEND ? SLOT_W'(NUM_SLOTS - 1) : '0;

   sc_state_e         st_q;
   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] next_slot;
   logic              last_slot;
   logic [1:0]        word_q;
   logic [31:0]       size_q;
   logic              hdr_bad;
   logic              hdr_good;

   generate
      if (SCAN_DESCEND) begin : g_desc
         assign next_slot = slot_q - SLOT_W'(1);
         assign last_slot = (slot_q == '0);
      end else begin : g_asc
         assign next_slot = slot_q + SLOT_W'(1);
         assign last_slot = (slot_q == SLOT_W'(NUM_SLOTS - 1));
      end
   endgenerate

   assign flash_rd   = (st_q == SC_ISSUE);
   assign flash_addr = (FLASH_AW'(slot_q) << SLOT_SHIFT) | FLASH_AW'(word_q);

   always_comb begin
      hdr_bad  = 1'b0;
      hdr_good = 1'b0;
      if (word_q == HW_MAGIC && flash_rdata != MAGIC) hdr_bad = 1'b1;
      if (word_q == HW_CHECK) begin
         if (flash_rdata == (size_q ^ CHK_SEED)) hdr_good = 1'b1;
         else                                    hdr_bad  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SC_ISSUE;
         slot_q     <= FIRST;
         word_q     <= HW_MAGIC;
         size_q     <= '0;
         scan_done  <= 1'b0;
         scan_found <= 1'b0;
         scan_slot  <= '0;
      end else begin
         scan_done <= 1'b0;
         case (st_q)
            SC_ISSUE: st_q <= SC_WAIT;
            SC_WAIT: if (flash_rvalid) begin
               if (hdr_bad) begin
                  if (last_slot) begin
                     st_q       <= SC_IDLE;
                     scan_done  <= 1'b1;
                     scan_found <= 1'b0;
                  end else begin
                     slot_q <= next_slot;
                     word_q <= HW_MAGIC;
                     st_q   <= SC_ISSUE;
                  end
               end else if (hdr_good) begin
                  st_q       <= SC_IDLE;
                  scan_done  <= 1'b1;
                  scan_found <= 1'b1;
                  scan_slot  <= slot_q;
               end else begin
                  if (word_q == HW_SIZE) size_q <= flash_rdata;
                  word_q <= word_q + 2'd1;
                  st_q   <= SC_ISSUE;
               end
            end
            default: ;
         endcase
      end
   end

   AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n) flash_rd |=> !flash_rd); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (st_q == SC_IDLE) |=> !flash_rd && !scan_done); // R3
endmodule

// File: rtl/cfg_wdog.sv
module cfg_wdog #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [TMO_W-1:0] tmo,
   output logic             expire
);
   logic [TMO_W-1:0] cnt_q;

   assign expire = arm && (({1'b0, cnt_q} + (TMO_W + 1)'(1)) >= {1'b0, tmo});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!arm)    cnt_q <= '0;
      else if (!expire) cnt_q <= cnt_q + TMO_W'(1);
   end

   AST_WD_LEAVES: assert property (@(posedge clk) disable iff (!rst_n) expire |=> !arm); // R6
endmodule

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq #(
   parameter int unsigned          NKEYS = 3,
   parameter logic [NKEYS*32-1:0]  KEYS  = {32'h0F1E_2D3C, 32'hA5A5_8765, 32'h5A5A_1234}
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        wr,
   input  logic [31:0] wdata,
   output logic        unlocked
);
   localparam int unsigned IDX_W = (NKEYS > 1) ? $clog2(NKEYS) : 1;

   logic [IDX_W-1:0] idx_q;
   logic [31:0]      want;
   logic             hit;
   logic             at_last;

   assign want     = KEYS[int'(idx_q)*32 +: 32];
   assign hit      = en && wr && (wdata == want);
   assign at_last  = (idx_q == IDX_W'(NKEYS - 1));
   assign unlocked = hit && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx_q <= '0;
      else if (!en) idx_q <= '0;
      else if (wr)  idx_q <= (hit && !at_last) ? idx_q + IDX_W'(1) : '0;
   end

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(idx_q) < NKEYS); // R8
   AST_UNLOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n) unlocked |=> !en); // R7
endmodule

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
   import cfg_guard_pkg::*;
#(
   parameter int unsigned         NUM_SLOTS    = 4,
   parameter int unsigned         FLASH_AW     = 8,
   parameter int unsigned         SLOT_SHIFT   = 4,
   parameter int unsigned         TMO_W        = 16,
   parameter logic [TMO_W-1:0]    DEF_TMO      = TMO_W'(1000),
   parameter logic [31:0]         MAGIC        = 32'hB17C_F00D,
   parameter logic [31:0]         CHK_SEED     = 32'h3C3C_C3C3,
   parameter int unsigned         NKEYS        = 3,
   parameter logic [NKEYS*32-1:0] KEYS         = {32'h0F1E_2D3C, 32'hA5A5_8765, 32'h5A5A_1234},
   parameter bit                  SCAN_DESCEND = 1'b0,
   localparam int unsigned        SLOT_W       = $clog2(NUM_SLOTS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_wr,
   input  logic [1:0]          host_addr,
   input  logic [31:0]         host_wdata,
   output logic [31:0]         host_rdata,
   output logic                flash_rd,
   output logic [FLASH_AW-1:0] flash_addr,
   input  logic                flash_rvalid,
   input  logic [31:0]         flash_rdata,
   output logic                cfg_start,
   output logic [SLOT_W-1:0]   cfg_slot,
   input  logic                cfg_done
);
   localparam logic [SLOT_W-1:0] FALLBACK = SLOT_W'(NUM_SLOTS);

   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > 255) begin : g_bad_slots
         $error("NUM_SLOTS must be 1..255");
      end
      if (SLOT_SHIFT < 2) begin : g_bad_shift
         $error("SLOT_SHIFT must leave room for three header words");
      end
      if (FLASH_AW < SLOT_SHIFT + $clog2(NUM_SLOTS)) begin : g_bad_aw
         $error("FLASH_AW too narrow for the slot array");
      end
      if (TMO_W < 2 || TMO_W > 32) begin : g_bad_tmo_w
         $error("TMO_W must be 2..32");
      end
      if (DEF_TMO == '0) begin : g_bad_def
         $error("DEF_TMO must be nonzero");
      end
      if (NKEYS < 2) begin : g_bad_keys
         $error("NKEYS must be at least 2");
      end
   endgenerate

   cg_state_e         state_q;
   logic [TMO_W-1:0]  tmo_q;
   logic              sticky_q;
   logic              wd_arm;
   logic              expire;
   logic              unlocked;
   logic              scan_done;
   logic              scan_found;
   logic [SLOT_W-1:0] scan_slot;

   assign wd_arm = (state_q == CG_ARMED);

   cfg_hdr_scan #(
      .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .FLASH_AW(FLASH_AW), .SLOT_SHIFT(SLOT_SHIFT),
      .MAGIC(MAGIC), .CHK_SEED(CHK_SEED), .SCAN_DESCEND(SCAN_DESCEND)
   ) u_scan (
      .clk(clk), .rst_n(rst_n), .flash_rd(flash_rd), .flash_addr(flash_addr),
      .flash_rvalid(flash_rvalid), .flash_rdata(flash_rdata),
      .scan_done(scan_done), .scan_found(scan_found), .scan_slot(scan_slot)
   );

   cfg_wdog #(.TMO_W(TMO_W)) u_wdog (
      .clk(clk), .rst_n(rst_n), .arm(wd_arm), .tmo(tmo_q), .expire(expire)
   );

   cfg_unlock_seq #(.NKEYS(NKEYS), .KEYS(KEYS)) u_unlock (
      .clk(clk), .rst_n(rst_n), .en(wd_arm),
      .wr(host_wr && host_addr == REG_UNLOCK), .wdata(host_wdata), .unlocked(unlocked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= CG_SCAN;
         cfg_slot  <= FALLBACK;
         cfg_start <= 1'b0;
         tmo_q     <= DEF_TMO;
         sticky_q  <= 1'b0;
      end else begin
         cfg_start <= 1'b0;
         if (host_wr && host_addr == REG_TMO && host_wdata[TMO_W-1:0] != '0)
            tmo_q <= host_wdata[TMO_W-1:0];
         case (state_q)
            CG_SCAN: if (scan_done) begin
               cfg_slot  <= scan_found ? scan_slot : FALLBACK;
               cfg_start <= 1'b1;
               state_q   <= CG_WAIT;
            end
            CG_WAIT: if (cfg_done) state_q <= (cfg_slot == FALLBACK) ? CG_SAFE : CG_ARMED;
            CG_ARMED: begin
               if (unlocked) begin
                  state_q <= CG_FREE;
               end else if (expire) begin
                  cfg_slot  <= FALLBACK;
                  cfg_start <= 1'b1;
                  sticky_q  <= 1'b1;
                  state_q   <= CG_WAIT;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (host_addr)
         REG_TMO:    host_rdata = 32'(tmo_q);
         REG_STATUS: host_rdata = 32'({sticky_q, wd_arm, 8'(cfg_slot)});
         default:    host_rdata = '0;
      endcase
   end

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cfg_start |=> !cfg_start); // R4
   AST_USER_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CG_WAIT && cfg_done && cfg_slot != FALLBACK) |=> wd_arm); // R5
   AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_arm && expire && !unlocked) |=> cfg_start && cfg_slot == FALLBACK); // R6
   AST_UNLOCK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_arm && unlocked) |=> state_q == CG_FREE && !cfg_start); // R12
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) sticky_q |=> sticky_q); // R9
   AST_SAFE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CG_SAFE) |=> state_q == CG_SAFE && !cfg_start); // R10
endmodule

// File: tb/tb_cfg_guard_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_guard_ctrl;
   localparam logic [31:0] MAGIC = 32'hB17C_F00D;
   localparam logic [31:0] SEED  = 32'h3C3C_C3C3;
   localparam logic [31:0] K0 = 32'h5A5A_1234, K1 = 32'hA5A5_8765, K2 = 32'h0F1E_2D3C;
   localparam int DONE_LAT = 3;
   localparam int FB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [1:0]  host_addr = 2'd0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        flash_rd;
   logic [7:0]  flash_addr;
   logic        flash_rvalid = 1'b0;
   logic [31:0] flash_rdata = '0;
   logic        cfg_start;
   logic [2:0]  cfg_slot;
   logic        cfg_done = 1'b0;

   always #4 clk = ~clk;

   cfg_guard_ctrl dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .flash_rd(flash_rd),
      .flash_addr(flash_addr), .flash_rvalid(flash_rvalid), .flash_rdata(flash_rdata),
      .cfg_start(cfg_start), .cfg_slot(cfg_slot), .cfg_done(cfg_done)
   );

   int kind [16];
   int cyc = 0;
   int n_starts, st_edge, st_slot, dn_edge, dcnt;
   logic p_v = 1'b0;
   logic [7:0] p_a = '0;
   logic prev_start, wide, addr_bad;
   int n_chk = 0, n_fail = 0;

   function automatic logic [31:0] hdr_word(input logic [7:0] a);
      int s, w;
      logic [31:0] sz;
      s  = int'(a[7:4]);
      w  = int'(a[3:0]);
      sz = 32'h100 + 32'(s * 7);
      case (w)
         0: return (kind[s] == 1) ? (MAGIC ^ 32'h1) : MAGIC;
         1: return sz;
         2: return (kind[s] == 2) ? (sz ^ SEED ^ 32'h4) : (sz ^ SEED);
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      p_v <= flash_rd;
      p_a <= flash_addr;
      flash_rvalid <= p_v;
      flash_rdata  <= hdr_word(p_a);
      cfg_done <= 1'b0;
      if (!rst_n) begin
         n_starts <= 0; st_edge <= 0; st_slot <= 0; dn_edge <= 0; dcnt <= 0;
         prev_start <= 1'b0; wide <= 1'b0; addr_bad <= 1'b0;
      end else begin
         if (flash_rd && flash_addr[3:0] > 4'd2) addr_bad <= 1'b1;
         if (cfg_start) begin
            n_starts <= n_starts + 1;
            st_edge  <= cyc;
            st_slot  <= int'(cfg_slot);
            dcnt     <= DONE_LAT;
            if (prev_start) wide <= 1'b1;
         end else if (dcnt != 0) begin
            dcnt <= dcnt - 1;
            if (dcnt == 1) cfg_done <= 1'b1;
         end
         prev_start <= cfg_start;
         if (cfg_done) dn_edge <= cyc;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      host_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic host_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      host_addr = a;
      #1 v = host_rdata;
   endtask

   task automatic wait_starts(input int n);
      while (n_starts < n) @(negedge clk);
   endtask

   function automatic logic [31:0] stat(input int slot, input bit armed, input bit sticky);
      return 32'(slot) | (32'(armed) << 8) | (32'(sticky) << 9);
   endfunction

   task automatic set_mask(input int mask);
      for (int s = 0; s < 16; s++)
         kind[s] = (s < 4 && mask[s]) ? 0 : ((s % 2 == 0) ? 1 : 2);
   endtask

   task automatic run_all();
      logic [31:0] v;
      int t, exp_slot;
      // R1 / R3 / R5 / R10: all slots bad
      set_mask(0);
      do_reset();
      host_read(2'd2, v); chk(v == stat(FB, 0, 0), "R1 status after reset", v, stat(FB, 0, 0));
      host_read(2'd1, v); chk(v == 32'd1000, "R1 default timeout", v, 32'd1000);
      wait_starts(1);
      chk(st_slot == FB, "R3 no good slot loads fallback", 32'(st_slot), 32'(FB));
      repeat (8) @(negedge clk);
      host_read(2'd2, v); chk(v == stat(FB, 0, 0), "R5 fallback load not armed", v, stat(FB, 0, 0));
      repeat (300) @(negedge clk);
      chk(n_starts == 1, "R10 no reload under fallback", 32'(n_starts), 32'd1);

      // R2 / R3 / R5 / R6 / R9 / R10: sweep of good-slot masks
      for (int m = 1; m < 16; m++) begin
         set_mask(m);
         t = 4 + m;
         exp_slot = 0;
         while (!m[exp_slot]) exp_slot++;
         do_reset();
         host_write(2'd1, 32'(t));
         wait_starts(1);
         chk(st_slot == exp_slot, "R3 lowest good slot", 32'(st_slot), 32'(exp_slot));
         repeat (5) @(negedge clk);
         host_read(2'd2, v);
         chk(v == stat(exp_slot, 1, 0), "R5 armed after user load", v, stat(exp_slot, 1, 0));
         wait_starts(2);
         chk(st_slot == FB, "R6 reload uses fallback", 32'(st_slot), 32'(FB));
         chk(st_edge == dn_edge + t + 1, "R6 timeout edge", 32'(st_edge - dn_edge), 32'(t + 1));
         repeat (8) @(negedge clk);
         host_read(2'd2, v);
         chk(v == stat(FB, 0, 1), "R9 sticky set, R10 not armed", v, stat(FB, 0, 1));
         repeat (60) @(negedge clk);
         chk(n_starts == 2, "R10 single reload", 32'(n_starts), 32'd2);
         host_read(2'd2, v);
         chk(v[9] == 1'b1, "R9 sticky holds", v, stat(FB, 0, 1));
      end
      chk(!addr_bad, "R2 header word offsets", 32'(addr_bad), 32'd0);
      chk(!wide, "R4 start pulse one cycle", 32'(wide), 32'd0);

      // R7: clean unlock
      set_mask(4'b0100);
      do_reset();
      host_write(2'd1, 32'd300);
      wait_starts(1);
      repeat (6) @(negedge clk);
      host_write(2'd0, K0); host_write(2'd0, K1); host_write(2'd0, K2);
      host_read(2'd2, v); chk(v == stat(2, 0, 0), "R7 unlock disarms", v, stat(2, 0, 0));
      repeat (400) @(negedge clk);
      chk(n_starts == 1, "R7 no reload after unlock", 32'(n_starts), 32'd1);

      // R8: wrong values reset the match
      set_mask(4'b0010);
      do_reset();
      host_write(2'd1, 32'd500);
      wait_starts(1);
      repeat (6) @(negedge clk);
      host_write(2'd0, K0); host_write(2'd0, K1); host_write(2'd0, 32'hDEAD_BEEF); host_write(2'd0, K2);
      host_read(2'd2, v); chk(v == stat(1, 1, 0), "R8 broken sequence stays armed", v, stat(1, 1, 0));
      host_write(2'd0, K0); host_write(2'd0, K0); host_write(2'd0, K1); host_write(2'd0, K2);
      host_read(2'd2, v); chk(v == stat(1, 1, 0), "R8 repeated key0 stays armed", v, stat(1, 1, 0));
      host_write(2'd0, K0); host_write(2'd0, K1); host_write(2'd0, K2);
      host_read(2'd2, v); chk(v == stat(1, 0, 0), "R8 clean retry unlocks", v, stat(1, 0, 0));
      repeat (520) @(negedge clk);
      chk(n_starts == 1, "R8 no reload after retry", 32'(n_starts), 32'd1);

      // R12: keys before arming are ignored
      set_mask(4'b0001);
      do_reset();
      host_write(2'd1, 32'd40);
      host_write(2'd0, K0); host_write(2'd0, K1);
      chk(n_starts == 0, "R12 keys sent before load", 32'(n_starts), 32'd0);
      wait_starts(1);
      repeat (6) @(negedge clk);
      host_write(2'd0, K2);
      host_read(2'd2, v); chk(v == stat(0, 1, 0), "R12 early keys ignored", v, stat(0, 1, 0));
      wait_starts(2);
      chk(st_slot == FB, "R12 timeout still reloads", 32'(st_slot), 32'(FB));

      // R12: final key on the expiry edge
      set_mask(4'b1000);
      do_reset();
      host_write(2'd1, 32'd20);
      wait_starts(1);
      repeat (6) @(negedge clk);
      host_write(2'd0, K0); host_write(2'd0, K1);
      @(negedge clk);
      while (cyc < dn_edge + 20) @(negedge clk);
      host_wr = 1'b1; host_addr = 2'd0; host_wdata = K2;
      @(negedge clk);
      host_wr = 1'b0;
      host_read(2'd2, v); chk(v == stat(3, 0, 0), "R12 unlock beats expiry", v, stat(3, 0, 0));
      repeat (50) @(negedge clk);
      chk(n_starts == 1, "R12 no reload on race", 32'(n_starts), 32'd1);

      // R11: timeout register
      set_mask(0);
      do_reset();
      host_write(2'd1, 32'h0001_0000);
      host_read(2'd1, v); chk(v == 32'd1000, "R11 zero write ignored", v, 32'd1000);
      host_write(2'd1, 32'h0001_2345);
      host_read(2'd1, v); chk(v == 32'h2345, "R11 timeout readback", v, 32'h2345);
   endtask

   initial begin
      bit hung;
      hung = 1'b0;
      set_mask(0);
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            hung = 1'b1;
         end
      join_any
      if (hung) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule